// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous two-port word store with two symmetric ports, called left and right. Either port can read or write any word on each rising clock edge, and each port returns its read data one cycle after the read is accepted. Each port has an active-low enable, a read/write select, an active-low output enable and an active-low hold input. While a port's hold input is low, that port's writes are thrown away. The logic that decides when to assert hold lives outside this block.

The two highest word addresses also act as a doorbell between the ports. The top address belongs to the right port and the one below it belongs to the left port. When one port writes the other port's mailbox word, the other port's active-low interrupt output goes low. The interrupt stays low until its owner reads that word back. The mailbox words are ordinary storage, so the reader also receives the message that was written there.

Top module: `dpram_mailbox`

## Requirements
- R1: A write is accepted when `en_n`=0, `rd`=0 and `hold_n`=1 at a clock edge. The word at `addr` then holds `wdata`, and any later read of that address through either port returns it.
- R2: A read is accepted when `en_n`=0 and `rd`=1 at a clock edge. One cycle later `rdata` holds the word as it was before that edge, and `rvalid` is 1 exactly when `oe_n` was also 0. When no read is accepted, `rvalid` is 0 and `rdata` keeps its last value.
- R3: When `en_n`=1, the port neither writes nor reads, and its `rvalid` is 0 the next cycle.
- R4: A write presented with `hold_n`=0 leaves memory unchanged and raises no interrupt.
- R5: An accepted left write to address 2^AW-1 (0x7FF by default) drives `r_irq_n` low from the next cycle.
- R6: An accepted right read of address 2^AW-1 drives `r_irq_n` high from the next cycle, whatever `r_oe_n` is.
- R7: An accepted right write to address 2^AW-2 (0x7FE by default) drives `l_irq_n` low from the next cycle.
- R8: An accepted left read of address 2^AW-2 drives `l_irq_n` high from the next cycle, whatever `l_oe_n` is.
- R9: If the set event and the clear event for the same interrupt occur in one cycle, the interrupt ends up set (low). With no event, the interrupt keeps its level.
- R10: A read of a mailbox address returns the last word written to that address.
- R11: While `rst` is high at a clock edge, both `irq_n` outputs go to 1, both `rvalid` outputs go to 0 and both `rdata` outputs go to 0.
- R12: If both ports write the same address in one cycle, the left port's data is kept. A read through one port of an address that the other port writes in the same cycle returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_en_n | input | 1 | Left port enable, active low |
| l_rd | input | 1 | Left select: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_hold_n | input | 1 | Left write permit, low discards writes |
| l_addr | input | AW (11) | Left word address |
| l_wdata | input | DW (9) | Left write data |
| l_rdata | output | DW (9) | Left read data, registered |
| l_rvalid | output | 1 | Left read data is valid |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_en_n | input | 1 | Right port enable, active low |
| r_rd | input | 1 | Right select: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_hold_n | input | 1 | Right write permit, low discards writes |
| r_addr | input | AW (11) | Right word address |
| r_wdata | input | DW (9) | Right write data |
| r_rdata | output | DW (9) | Right read data, registered |
| r_rvalid | output | 1 | Right read data is valid |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. A write is visible to a read issued on the following edge. Read data and its valid flag appear after the edge that accepts the read, and an interrupt falls or rises after the edge on which the mailbox event occurs. The bench changes inputs 2 ns after an edge. It computes the expected outputs from its own memory and flag model before it applies that edge's updates, and it compares them 2 ns after the next edge, which keeps every check one cycle behind its stimulus.

// File: rtl/dpram_mailbox_pkg.sv
package dpram_mailbox_pkg;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  // Mailbox word owned by a side: right owns the top word, left the one below
  function automatic int box_addr(input int aw, input side_e s);
    return (1 << aw) - ((s == SIDE_R) ? 1 : 2);
  endfunction

endpackage

// File: rtl/dpram_port_dec.sv
module dpram_port_dec #(
  parameter int AW = 11,
  parameter logic [AW-1:0] OWN_BOX  = '1,
  parameter logic [AW-1:0] PEER_BOX = '0
) (
  input  logic          en_n,
  input  logic          rd,
  input  logic          oe_n,
  input  logic          hold_n,
  input  logic [AW-1:0] addr,
  output logic          wr_go,
  output logic          rd_go,
  output logic          rd_show,
  output logic          peer_set,
  output logic          own_clr
);

  always_comb begin
    wr_go    = !en_n && !rd && hold_n;
    rd_go    = !en_n && rd;
    rd_show  = rd_go && !oe_n;
    peer_set = wr_go && (addr == PEER_BOX);
    own_clr  = rd_go && (addr == OWN_BOX);
  end

endmodule

// File: rtl/dpram_irq_flag.sv
module dpram_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int AW = 11,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_rd,
  input  logic          b_we,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_rd
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Writes: port b first so that port a wins on a shared address
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wd;
    if (a_we) mem[a_addr] <= a_wd;
  end

  // Registered reads, read-before-write
  always_ff @(posedge clk) begin
    if (rst) begin
      a_rd <= '0;
      b_rd <= '0;
    end else begin
      if (a_re) a_rd <= mem[a_addr];
      if (b_re) b_rd <= mem[b_addr];
    end
  end

endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
  import dpram_mailbox_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_en_n,
  input  logic          l_rd,
  input  logic          l_oe_n,
  input  logic          l_hold_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rvalid,
  output logic          l_irq_n,
  input  logic          r_en_n,
  input  logic          r_rd,
  input  logic          r_oe_n,
  input  logic          r_hold_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rvalid,
  output logic          r_irq_n
);

  localparam int NSIDE = 2;
  localparam logic [AW-1:0] L_BOX = AW'(box_addr(AW, SIDE_L));
  localparam logic [AW-1:0] R_BOX = AW'(box_addr(AW, SIDE_R));

  logic [NSIDE-1:0]  en_n, rd, oe_n, hold_n;
  logic [AW-1:0]     addr [NSIDE];
  logic [NSIDE-1:0]  wr_go, rd_go, rd_show, peer_set, own_clr, flag;
  logic [NSIDE-1:0]  show_q;

  assign en_n    = {r_en_n, l_en_n};
  assign rd      = {r_rd, l_rd};
  assign oe_n    = {r_oe_n, l_oe_n};
  assign hold_n  = {r_hold_n, l_hold_n};
  assign addr[0] = l_addr;
  assign addr[1] = r_addr;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam logic [AW-1:0] OWN  = (s == 0) ? L_BOX : R_BOX;
    localparam logic [AW-1:0] PEER = (s == 0) ? R_BOX : L_BOX;

    dpram_port_dec #(
      .AW      (AW),
      .OWN_BOX (OWN),
      .PEER_BOX(PEER)
    ) u_dec (
      .en_n    (en_n[s]),
      .rd      (rd[s]),
      .oe_n    (oe_n[s]),
      .hold_n  (hold_n[s]),
      .addr    (addr[s]),
      .wr_go   (wr_go[s]),
      .rd_go   (rd_go[s]),
      .rd_show (rd_show[s]),
      .peer_set(peer_set[s]),
      .own_clr (own_clr[s])
    );

    // This side's flag is set by the other side's write and cleared by own read
    dpram_irq_flag u_flag (
      .clk (clk),
      .rst (rst),
      .set (peer_set[NSIDE-1-s]),
      .clr (own_clr[s]),
      .flag(flag[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) show_q <= '0;
    else     show_q <= rd_show;
  end

  dpram_store #(
    .AW(AW),
    .DW(DW)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .a_we  (wr_go[0]),
    .a_re  (rd_go[0]),
    .a_addr(l_addr),
    .a_wd  (l_wdata),
    .a_rd  (l_rdata),
    .b_we  (wr_go[1]),
    .b_re  (rd_go[1]),
    .b_addr(r_addr),
    .b_wd  (r_wdata),
    .b_rd  (r_rdata)
  );

  assign l_rvalid = show_q[0];
  assign r_rvalid = show_q[1];
  assign l_irq_n  = !flag[0];
  assign r_irq_n  = !flag[1];

endmodule

// File: rtl/dpram_mailbox_chk.sv
module dpram_mailbox_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          l_en_n,
  input logic          l_rd,
  input logic          l_oe_n,
  input logic          l_hold_n,
  input logic [AW-1:0] l_addr,
  input logic          l_rvalid,
  input logic          l_irq_n,
  input logic          r_en_n,
  input logic          r_rd,
  input logic          r_oe_n,
  input logic          r_hold_n,
  input logic [AW-1:0] r_addr,
  input logic          r_rvalid,
  input logic          r_irq_n
);

  localparam logic [AW-1:0] TOP  = '1;
  localparam logic [AW-1:0] TOP1 = TOP - 1'b1;

  logic l_set_r, r_clr_r, r_set_l, l_clr_l;
  assign l_set_r = !l_en_n && !l_rd && l_hold_n && (l_addr == TOP);
  assign r_clr_r = !r_en_n && r_rd && (r_addr == TOP);
  assign r_set_l = !r_en_n && !r_rd && r_hold_n && (r_addr == TOP1);
  assign l_clr_l = !l_en_n && l_rd && (l_addr == TOP1);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (l_irq_n && r_irq_n && !l_rvalid && !r_rvalid)); // R11
  AST_RIGHT_SET: assert property (@(posedge clk) disable iff (rst)
    l_set_r |=> !r_irq_n); // R5
  AST_RIGHT_CLR: assert property (@(posedge clk) disable iff (rst)
    (r_clr_r && !l_set_r) |=> r_irq_n); // R6
  AST_LEFT_SET: assert property (@(posedge clk) disable iff (rst)
    r_set_l |=> !l_irq_n); // R7
  AST_LEFT_CLR: assert property (@(posedge clk) disable iff (rst)
    (l_clr_l && !r_set_l) |=> l_irq_n); // R8
  AST_IRQ_KEEP_R: assert property (@(posedge clk) disable iff (rst)
    (!l_set_r && !r_clr_r) |=> $stable(r_irq_n)); // R9
  AST_IRQ_KEEP_L: assert property (@(posedge clk) disable iff (rst)
    (!r_set_l && !l_clr_l) |=> $stable(l_irq_n)); // R9
  AST_LVALID: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (l_rvalid == $past(!l_en_n && l_rd && !l_oe_n))); // R2
  AST_RVALID: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (r_rvalid == $past(!r_en_n && r_rd && !r_oe_n))); // R2
  AST_OFF_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    (l_en_n && r_en_n) |=> (!l_rvalid && !r_rvalid)); // R3

endmodule

bind dpram_mailbox dpram_mailbox_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .l_en_n  (l_en_n),
  .l_rd    (l_rd),
  .l_oe_n  (l_oe_n),
  .l_hold_n(l_hold_n),
  .l_addr  (l_addr),
  .l_rvalid(l_rvalid),
  .l_irq_n (l_irq_n),
  .r_en_n  (r_en_n),
  .r_rd    (r_rd),
  .r_oe_n  (r_oe_n),
  .r_hold_n(r_hold_n),
  .r_addr  (r_addr),
  .r_rvalid(r_rvalid),
  .r_irq_n (r_irq_n)
);

// File: tb/dpram_mailbox_bench.sv
module dpram_mailbox_bench;

  localparam int AW = 11;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] TOP  = '1;
  localparam logic [AW-1:0] TOP1 = TOP - 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic          l_en_n = 1'b1, l_rd = 1'b0, l_oe_n = 1'b1, l_hold_n = 1'b1;
  logic [AW-1:0] l_addr = '0;
  logic [DW-1:0] l_wdata = '0;
  logic [DW-1:0] l_rdata;
  logic          l_rvalid, l_irq_n;
  logic          r_en_n = 1'b1, r_rd = 1'b0, r_oe_n = 1'b1, r_hold_n = 1'b1;
  logic [AW-1:0] r_addr = '0;
  logic [DW-1:0] r_wdata = '0;
  logic [DW-1:0] r_rdata;
  logic          r_rvalid, r_irq_n;

  always #4 clk = !clk;

  dpram_mailbox #(.AW(AW), .DW(DW)) u_dpram_mailbox (
    .clk(clk), .rst(rst),
    .l_en_n(l_en_n), .l_rd(l_rd), .l_oe_n(l_oe_n), .l_hold_n(l_hold_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .l_rvalid(l_rvalid), .l_irq_n(l_irq_n),
    .r_en_n(r_en_n), .r_rd(r_rd), .r_oe_n(r_oe_n), .r_hold_n(r_hold_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .r_rvalid(r_rvalid), .r_irq_n(r_irq_n)
  );

  // Bench model
  logic [DW-1:0] mdl   [DEPTH];
  bit            known [DEPTH];
  logic [DW-1:0] e_l_data = '0, e_r_data = '0;
  bit            e_l_known = 1'b1, e_r_known = 1'b1;
  bit            e_l_val = 1'b0, e_r_val = 1'b0;
  bit            e_l_flag = 1'b0, e_r_flag = 1'b0;

  int total = 0;
  int bad   = 0;

  function automatic bit next_flag(bit cur, bit set, bit clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  function automatic bit accepts_write(bit en_n, bit rd, bit hold_n);
    return !en_n && !rd && hold_n;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_both();
    l_en_n = 1'b1; l_rd = 1'b0; l_oe_n = 1'b1; l_hold_n = 1'b1;
    r_en_n = 1'b1; r_rd = 1'b0; r_oe_n = 1'b1; r_hold_n = 1'b1;
  endtask

  task automatic step(string tag);
    bit lw, lr, rw, rr;
    lw = accepts_write(l_en_n, l_rd, l_hold_n);
    rw = accepts_write(r_en_n, r_rd, r_hold_n);
    lr = !l_en_n && l_rd;
    rr = !r_en_n && r_rd;
    if (lr) begin e_l_data = mdl[l_addr]; e_l_known = known[l_addr]; end
    if (rr) begin e_r_data = mdl[r_addr]; e_r_known = known[r_addr]; end
    e_l_val  = lr && !l_oe_n;
    e_r_val  = rr && !r_oe_n;
    e_r_flag = next_flag(e_r_flag, lw && l_addr == TOP,  rr && r_addr == TOP);
    e_l_flag = next_flag(e_l_flag, rw && r_addr == TOP1, lr && l_addr == TOP1);
    if (rw) begin mdl[r_addr] = r_wdata; known[r_addr] = 1'b1; end
    if (lw) begin mdl[l_addr] = l_wdata; known[l_addr] = 1'b1; end
    @(posedge clk);
    #2;
    chk(tag, "l_rvalid", 32'(l_rvalid), 32'(e_l_val));
    chk(tag, "r_rvalid", 32'(r_rvalid), 32'(e_r_val));
    chk(tag, "l_irq_n",  32'(l_irq_n),  32'(!e_l_flag));
    chk(tag, "r_irq_n",  32'(r_irq_n),  32'(!e_r_flag));
    if (e_l_known) chk(tag, "l_rdata", 32'(l_rdata), 32'(e_l_data));
    if (e_r_known) chk(tag, "r_rdata", 32'(r_rdata), 32'(e_r_data));
  endtask

  task automatic l_write(logic [AW-1:0] a, logic [DW-1:0] d);
    l_en_n = 1'b0; l_rd = 1'b0; l_addr = a; l_wdata = d;
  endtask
  task automatic r_write(logic [AW-1:0] a, logic [DW-1:0] d);
    r_en_n = 1'b0; r_rd = 1'b0; r_addr = a; r_wdata = d;
  endtask
  task automatic l_read(logic [AW-1:0] a, bit oe_n);
    l_en_n = 1'b0; l_rd = 1'b1; l_addr = a; l_oe_n = oe_n;
  endtask
  task automatic r_read(logic [AW-1:0] a, bit oe_n);
    r_en_n = 1'b0; r_rd = 1'b1; r_addr = a; r_oe_n = oe_n;
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int sel = int'($urandom % 8);
    if (sel == 0) return TOP;
    if (sel == 1) return TOP1;
    if (sel == 2) return AW'($urandom);
    return AW'($urandom % 24);
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      known[i] = 1'b0;
      mdl[i] = '0;
    end
    void'($urandom(32'd20240611));
    idle_both();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    // R11: state after reset
    chk("R11", "l_irq_n", 32'(l_irq_n), 32'd1);
    chk("R11", "r_irq_n", 32'(r_irq_n), 32'd1);
    chk("R11", "l_rvalid", 32'(l_rvalid), 32'd0);
    chk("R11", "r_rvalid", 32'(r_rvalid), 32'd0);
    chk("R11", "l_rdata", 32'(l_rdata), 32'd0);
    chk("R11", "r_rdata", 32'(r_rdata), 32'd0);

    // R1 write left, read through right
    l_write(11'd5, 9'h1A5); step("R1");
    idle_both(); r_read(11'd5, 1'b0); step("R1");
    // R2 read with output disabled: no valid
    idle_both(); l_read(11'd5, 1'b1); step("R2");
    idle_both(); l_read(11'd5, 1'b0); step("R2");
    idle_both(); step("R2");
    // R3 disabled port: write attempt ignored
    l_en_n = 1'b1; l_rd = 1'b0; l_addr = 11'd5; l_wdata = 9'h0F0; step("R3");
    idle_both(); r_read(11'd5, 1'b0); step("R3");
    // R4 held write discarded, both ordinary and mailbox
    idle_both(); l_write(11'd5, 9'h033); l_hold_n = 1'b0; step("R4");
    idle_both(); l_write(TOP, 9'h044); l_hold_n = 1'b0; step("R4");
    idle_both(); r_read(11'd5, 1'b0); step("R4");
    // R5 / R7 mailbox sets
    idle_both(); l_write(TOP, 9'h155); r_write(TOP1, 9'h0AA); step("R5 R7");
    idle_both(); step("R5 R7");
    // R6 clear with output disabled, R10 data is the message
    idle_both(); r_read(TOP, 1'b1); step("R6");
    idle_both(); r_read(TOP, 1'b0); step("R10");
    // R8 clear of left flag
    idle_both(); l_read(TOP1, 1'b0); step("R8 R10");
    // R9 set and clear in one cycle: set wins
    idle_both(); l_write(TOP, 9'h001); r_read(TOP, 1'b0); step("R9");
    idle_both(); r_write(TOP1, 9'h002); l_read(TOP1, 1'b0); step("R9");
    idle_both(); step("R9");
    idle_both(); r_read(TOP, 1'b0); l_read(TOP1, 1'b0); step("R9");
    // R12 both write same word: left kept
    idle_both(); l_write(11'd9, 9'h111); r_write(11'd9, 9'h0EE); step("R12");
    idle_both(); r_read(11'd9, 1'b0); step("R12");
    // R12 read of a word being written by the other port gives old contents
    idle_both(); l_write(11'd9, 9'h077); r_read(11'd9, 1'b0); step("R12");
    idle_both(); r_read(11'd9, 1'b0); step("R12");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      l_en_n   = ($urandom % 5) == 0;
      l_rd     = $urandom % 2;
      l_oe_n   = ($urandom % 4) == 0;
      l_hold_n = ($urandom % 6) != 0;
      l_addr   = pick_addr();
      l_wdata  = DW'($urandom);
      r_en_n   = ($urandom % 5) == 0;
      r_rd     = $urandom % 2;
      r_oe_n   = ($urandom % 4) == 0;
      r_hold_n = ($urandom % 6) != 0;
      r_addr   = pick_addr();
      r_wdata  = DW'($urandom);
      step("random R1 R2 R4 R5 R6 R7 R8");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule